// File: doc/BRIEF.md
# Lockable Translation Cache with Victim Pointer

This block is a small fully associative cache of address translations for a device-side memory management unit. Each slot holds a tag word and a data word. The tag word carries a virtual page number, a two-bit page-size code, a valid bit and a preserve bit. The data word carries a physical page number and a few attribute bits. A lookup port takes a device virtual address. One clock later it returns whether any valid slot covers that address, the translated physical address and the slot's attributes.

Software maintains the contents through a command interface. A lock pair (a base index and a victim index) controls replacement. Slots below the base are never picked by the automatic wrap, and the victim index names the slot that the next load overwrites. A tag/data staging pair is the window to the contents. Software writes it before a load, and a read command copies the slot at the victim index into it, so every slot can be read back. Other commands invalidate the slots that cover one address, or clear every slot that is not preserved.

The controller is a state machine with five states. IDLE accepts commands. PREFLUSH is entered on an accepted load. It invalidates every valid slot that covers the staged virtual address, then always moves to WRITE. WRITE stores the staged pair at the victim slot, advances the victim index and returns to IDLE. FLUSH_VA is entered on a flush-by-address command. It invalidates the covering slots and returns to IDLE. FLUSH_ALL is entered on a flush-all command. It clears the slots that are not preserved, zeroes the lock pair and returns to IDLE. A load that cannot be placed is rejected in IDLE and causes no state change. Lock write, stage write and read complete in IDLE in a single cycle.

Top module: `tlb_lockable`

## Requirements
- R1: After reset every slot is invalid, both lock indices are 0, busy is low, and a lookup reports a miss.
- R2: Command code 1 (lock write) sets the base and victim indices from the command inputs in one cycle. Both indices stay unchanged while no command is given.
- R3: Command code 2 stages a tag/data pair. Command code 3 (load) writes the staged pair into the slot at the victim index. Command code 4 (read) copies the slot at the victim index back into the staging outputs. Tag bit 2 is valid, tag bit 3 is preserve, and tag bits 31:12 hold the virtual page number. Data bits 31:12 hold the physical page number and data bits 3:0 hold the attributes.
- R4: After a successful load the victim index increments. When the incremented value equals the entry count, the victim index takes the base value instead.
- R5: A load given while the base index equals the entry count (or the victim index is out of range) completes at once with the error flag set. It leaves the victim index and every slot unchanged.
- R6: Tag bits 1:0 select the page size: 0 is 4 KiB, 1 is 64 KiB, 2 is 1 MiB and 3 is 16 MiB. A lookup hits a slot when the address bits above that size equal the slot's page bits. The result takes the high bits from the physical page and the low bits (the offset) from the looked-up address.
- R7: Command code 5 (flush by address) invalidates every valid slot whose range [start, start + size) contains the given address, using each slot's own size. Other slots are untouched.
- R8: Command code 6 (flush all) invalidates every slot whose preserve bit is clear, keeps preserved slots, and sets both lock indices to 0.
- R9: When several slots match a lookup, the lowest-indexed one supplies the result. On a miss, hit, address and attributes are all 0.
- R10: A load first invalidates any valid slot that covers the staged virtual address, so a reload of a page never leaves a stale duplicate.
- R11: Busy is high while a load or flush is in progress. Commands are accepted only while busy is low. The done pulse is raised while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 3 | Command code (1 lock write, 2 stage, 3 load, 4 read, 5 flush address, 6 flush all) |
| cmd_base | input | LK_W | Base index for a lock write |
| cmd_vict | input | LK_W | Victim index for a lock write |
| cmd_tag | input | 32 | Tag word for a stage command |
| cmd_data | input | 32 | Data word for a stage command |
| cmd_va | input | 32 | Address for a flush by address |
| busy | output | 1 | Multi-cycle command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | With cmd_done: load rejected |
| lock_base | output | LK_W | Current base index |
| lock_vict | output | LK_W | Current victim index |
| stage_tag | output | 32 | Staged tag word |
| stage_data | output | 32 | Staged data word |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, one cycle after lk_va |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | ATTR_W | Attributes of the hitting slot |

## Verification
The bench places a 4 KiB page inside a 16 MiB page at a lower index. If priority went to the highest index, the larger page's translation would come back instead. It loads the victim index one slot below the entry count. A design that wrapped to zero, or that failed to wrap, would then overwrite a locked slot or run off the array. It reloads a page that is already present and reads back the old slot. A design without the pre-load invalidation would keep a stale duplicate valid. A flush by address inside the small page must remove both overlapping pages, and a design that compared only at 4 KiB granularity would keep the large page. Flush-all with a preserved slot shows whether the preserve bit is honoured and whether the lock pair returns to zero.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WORD_W    = 32;
    localparam int PAGE_LSB  = 12;
    localparam int TAG_VALID = 2;
    localparam int TAG_PRES  = 3;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_LOCK_WR   = 3'd1,
        OP_STAGE_WR  = 3'd2,
        OP_LOAD      = 3'd3,
        OP_READ      = 3'd4,
        OP_FLUSH_VA  = 3'd5,
        OP_FLUSH_ALL = 3'd6
    } tlb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFLUSH,
        ST_WRITE,
        ST_FLUSH_VA,
        ST_FLUSH_ALL
    } tlb_state_e;

    // Mask keeping the page-number bits for a size code (4K, 64K, 1M, 16M).
    function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] code);
        logic [WORD_W-1:0] m;
        unique case (code)
            2'd0:    m = 32'hFFFF_F000;
            2'd1:    m = 32'hFFFF_0000;
            2'd2:    m = 32'hFFF0_0000;
            default: m = 32'hFF00_0000;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] page_base(input logic [WORD_W-1:0] w);
        return {w[WORD_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ATTR_W  = 4,
    localparam int SLOT_W = $clog2(ENTRIES),
    localparam int RES_W  = WORD_W + ATTR_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SLOT_W-1:0]                 wr_idx,
    input  logic [WORD_W-1:0]                 wr_tag,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic [ENTRIES-1:0]                inv_mask,
    input  logic [WORD_W-1:0]                 lk_va,
    input  logic [WORD_W-1:0]                 fl_va,
    output logic [ENTRIES-1:0][WORD_W-1:0]    tag_q,
    output logic [ENTRIES-1:0][WORD_W-1:0]    data_q,
    output logic [ENTRIES-1:0]                lk_match,
    output logic [ENTRIES-1:0]                fl_match,
    output logic [ENTRIES-1:0][RES_W-1:0]     lk_res
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [WORD_W-1:0] msk;
        logic [WORD_W-1:0] vbase;
        logic [WORD_W-1:0] pbase;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (wr_en && (wr_idx == SLOT_W'(i))) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end else if (inv_mask[i]) begin
                tag_q[i][TAG_VALID] <= 1'b0;
            end
        end

        assign msk   = size_mask(tag_q[i][1:0]);
        assign vbase = page_base(tag_q[i]);
        assign pbase = page_base(data_q[i]);

        assign lk_match[i] = tag_q[i][TAG_VALID] && ((lk_va & msk) == (vbase & msk));
        assign fl_match[i] = tag_q[i][TAG_VALID] && ((fl_va & msk) == (vbase & msk));
        assign lk_res[i]   = {data_q[i][ATTR_W-1:0], (pbase & msk) | (lk_va & ~msk)};
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int ENTRIES = 32,
    parameter int RES_W   = 36
) (
    input  logic [ENTRIES-1:0]             req,
    input  logic [ENTRIES-1:0][RES_W-1:0]  val,
    output logic                           hit,
    output logic [RES_W-1:0]               res
);

    always_comb begin
        hit = 1'b0;
        res = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                res = val[i];
            end
        end
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int SLOT_W = $clog2(ENTRIES),
    localparam int LK_W   = $clog2(ENTRIES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_valid,
    input  logic [2:0]                      cmd_op,
    input  logic [LK_W-1:0]                 cmd_base,
    input  logic [LK_W-1:0]                 cmd_vict,
    input  logic [WORD_W-1:0]               cmd_tag,
    input  logic [WORD_W-1:0]               cmd_data,
    input  logic [WORD_W-1:0]               cmd_va,
    input  logic [ENTRIES-1:0][WORD_W-1:0]  tag_q,
    input  logic [ENTRIES-1:0][WORD_W-1:0]  data_q,
    input  logic [ENTRIES-1:0]              fl_match,
    output logic                            wr_en,
    output logic [SLOT_W-1:0]               wr_idx,
    output logic [WORD_W-1:0]               wr_tag,
    output logic [WORD_W-1:0]               wr_data,
    output logic [ENTRIES-1:0]              inv_mask,
    output logic [WORD_W-1:0]               fl_addr,
    output logic [LK_W-1:0]                 lock_base,
    output logic [LK_W-1:0]                 lock_vict,
    output logic [WORD_W-1:0]               stage_tag,
    output logic [WORD_W-1:0]               stage_data,
    output logic                            busy,
    output logic                            done,
    output logic                            err
);

    localparam logic [LK_W-1:0] LK_LIMIT = LK_W'(ENTRIES);

    tlb_state_e        state_q, state_d;
    tlb_op_e           op;
    logic              accept;
    logic              slots_ok;
    logic [LK_W-1:0]   base_q, vict_q, vict_inc;
    logic [WORD_W-1:0] stag_q, sdata_q, fva_q;
    logic [SLOT_W-1:0] vslot;

    assign op       = tlb_op_e'(cmd_op);
    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign slots_ok = (base_q < LK_LIMIT) && (vict_q < LK_LIMIT);
    assign vict_inc = vict_q + 1'b1;
    assign vslot    = vict_q[SLOT_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_LOAD:      state_d = slots_ok ? ST_PREFLUSH : ST_IDLE;
                        OP_FLUSH_VA:  state_d = ST_FLUSH_VA;
                        OP_FLUSH_ALL: state_d = ST_FLUSH_ALL;
                        default:      state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PREFLUSH:  state_d = ST_WRITE;
            ST_WRITE:     state_d = ST_IDLE;
            ST_FLUSH_VA:  state_d = ST_IDLE;
            ST_FLUSH_ALL: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        wr_en    = 1'b0;
        inv_mask = '0;
        fl_addr  = fva_q;
        unique case (state_q)
            ST_PREFLUSH: begin
                fl_addr  = page_base(stag_q);
                inv_mask = fl_match;
            end
            ST_WRITE:    wr_en = 1'b1;
            ST_FLUSH_VA: inv_mask = fl_match;
            ST_FLUSH_ALL: begin
                for (int i = 0; i < ENTRIES; i++)
                    inv_mask[i] = tag_q[i][TAG_VALID] && !tag_q[i][TAG_PRES];
            end
            default: ;
        endcase
    end

    assign wr_idx     = vslot;
    assign wr_tag     = stag_q;
    assign wr_data    = sdata_q;
    assign lock_base  = base_q;
    assign lock_vict  = vict_q;
    assign stage_tag  = stag_q;
    assign stage_data = sdata_q;

    // Lock pair, staging pair and completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            vict_q  <= '0;
            stag_q  <= '0;
            sdata_q <= '0;
            fva_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (op)
                            OP_LOCK_WR: begin
                                base_q <= cmd_base;
                                vict_q <= cmd_vict;
                                done   <= 1'b1;
                            end
                            OP_STAGE_WR: begin
                                stag_q  <= cmd_tag;
                                sdata_q <= cmd_data;
                                done    <= 1'b1;
                            end
                            OP_READ: begin
                                if (vict_q < LK_LIMIT) begin
                                    stag_q  <= tag_q[vslot];
                                    sdata_q <= data_q[vslot];
                                end else begin
                                    stag_q  <= '0;
                                    sdata_q <= '0;
                                end
                                done <= 1'b1;
                            end
                            OP_LOAD: begin
                                if (!slots_ok) begin
                                    done <= 1'b1;
                                    err  <= 1'b1;
                                end
                            end
                            OP_FLUSH_VA:  fva_q <= cmd_va;
                            OP_FLUSH_ALL: ;
                            default:      done <= 1'b1;
                        endcase
                    end
                end
                ST_PREFLUSH: ;
                ST_WRITE: begin
                    vict_q <= (vict_inc == LK_LIMIT) ? base_q : vict_inc;
                    done   <= 1'b1;
                end
                ST_FLUSH_VA: done <= 1'b1;
                ST_FLUSH_ALL: begin
                    base_q <= '0;
                    vict_q <= '0;
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tlb_lockable.sv
module tlb_lockable
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ATTR_W  = 4,
    localparam int LK_W   = $clog2(ENTRIES + 1),
    localparam int SLOT_W = $clog2(ENTRIES),
    localparam int RES_W  = WORD_W + ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LK_W-1:0]   cmd_base,
    input  logic [LK_W-1:0]   cmd_vict,
    input  logic [31:0]       cmd_tag,
    input  logic [31:0]       cmd_data,
    input  logic [31:0]       cmd_va,
    output logic              busy,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic [LK_W-1:0]   lock_base,
    output logic [LK_W-1:0]   lock_vict,
    output logic [31:0]       stage_tag,
    output logic [31:0]       stage_data,
    input  logic [31:0]       lk_va,
    output logic              lk_hit,
    output logic [31:0]       lk_pa,
    output logic [ATTR_W-1:0] lk_attr
);

    logic                             wr_en;
    logic [SLOT_W-1:0]                wr_idx;
    logic [WORD_W-1:0]                wr_tag, wr_data, fl_addr;
    logic [ENTRIES-1:0]               inv_mask, lk_match, fl_match;
    logic [ENTRIES-1:0][WORD_W-1:0]   tag_q, data_q;
    logic [ENTRIES-1:0][RES_W-1:0]    lk_res;
    logic                             pick_hit;
    logic [RES_W-1:0]                 pick_res;

    tlb_store #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .inv_mask (inv_mask),
        .lk_va    (lk_va),
        .fl_va    (fl_addr),
        .tag_q    (tag_q),
        .data_q   (data_q),
        .lk_match (lk_match),
        .fl_match (fl_match),
        .lk_res   (lk_res)
    );

    tlb_pick #(.ENTRIES(ENTRIES), .RES_W(RES_W)) u_pick (
        .req (lk_match),
        .val (lk_res),
        .hit (pick_hit),
        .res (pick_res)
    );

    tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_base   (cmd_base),
        .cmd_vict   (cmd_vict),
        .cmd_tag    (cmd_tag),
        .cmd_data   (cmd_data),
        .cmd_va     (cmd_va),
        .tag_q      (tag_q),
        .data_q     (data_q),
        .fl_match   (fl_match),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data),
        .inv_mask   (inv_mask),
        .fl_addr    (fl_addr),
        .lock_base  (lock_base),
        .lock_vict  (lock_vict),
        .stage_tag  (stage_tag),
        .stage_data (stage_data),
        .busy       (busy),
        .done       (cmd_done),
        .err        (cmd_err)
    );

    // Registered lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_pa   <= '0;
            lk_attr <= '0;
        end else begin
            lk_hit  <= pick_hit;
            lk_pa   <= pick_res[WORD_W-1:0];
            lk_attr <= pick_res[RES_W-1:WORD_W];
        end
    end

endmodule

// File: rtl/tlb_lockable_chk.sv
module tlb_lockable_chk #(
    parameter int ENTRIES = 32,
    parameter int ATTR_W  = 4,
    localparam int LK_W   = $clog2(ENTRIES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic              cmd_done,
    input logic              cmd_err,
    input logic [LK_W-1:0]   lock_base,
    input logic [LK_W-1:0]   lock_vict,
    input logic              lk_hit,
    input logic [31:0]       lk_pa,
    input logic [ATTR_W-1:0] lk_attr
);

    localparam logic [LK_W-1:0] LK_LIMIT = LK_W'(ENTRIES);

    a_r9_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && lk_attr == '0));

    a_r5_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd3 && lock_base == LK_LIMIT)
        |=> (cmd_done && cmd_err && $stable(lock_vict)));

    a_r8_flush_all_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd6)
        |=> ##1 (lock_base == '0 && lock_vict == '0));

    a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !busy) |=> ($stable(lock_base) && $stable(lock_vict)));

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !busy);

endmodule

bind tlb_lockable tlb_lockable_chk #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .cmd_done  (cmd_done),
    .cmd_err   (cmd_err),
    .lock_base (lock_base),
    .lock_vict (lock_vict),
    .lk_hit    (lk_hit),
    .lk_pa     (lk_pa),
    .lk_attr   (lk_attr)
);

// File: tb/tb_tlb_lockable.sv
`timescale 1ns/1ps
module tb_tlb_lockable;

    localparam int N    = 32;
    localparam int AW   = 4;
    localparam int LK_W = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [LK_W-1:0] cmd_base = '0, cmd_vict = '0;
    logic [31:0]     cmd_tag = '0, cmd_data = '0, cmd_va = '0;
    logic            busy, cmd_done, cmd_err;
    logic [LK_W-1:0] lock_base, lock_vict;
    logic [31:0]     stage_tag, stage_data;
    logic [31:0]     lk_va = '0;
    logic            lk_hit;
    logic [31:0]     lk_pa;
    logic [AW-1:0]   lk_attr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic last_err;

    always #4 clk = ~clk;

    tlb_lockable #(.ENTRIES(N), .ATTR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_vict(cmd_vict), .cmd_tag(cmd_tag),
        .cmd_data(cmd_data), .cmd_va(cmd_va), .busy(busy), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .lock_base(lock_base), .lock_vict(lock_vict),
        .stage_tag(stage_tag), .stage_data(stage_data), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int b, input int v,
                         input logic [31:0] tag, input logic [31:0] data, input logic [31:0] va);
        int guard;
        @(negedge clk);
        cmd_op    = op;
        cmd_base  = LK_W'(b);
        cmd_vict  = LK_W'(v);
        cmd_tag   = tag;
        cmd_data  = data;
        cmd_va    = va;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!cmd_done && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        last_err = cmd_err;
    endtask

    task automatic set_lock(input int b, input int v);
        issue(3'd1, b, v, '0, '0, '0);
    endtask

    task automatic load(input logic [31:0] tag, input logic [31:0] data);
        issue(3'd2, 0, 0, tag, data, '0);
        issue(3'd3, 0, 0, '0, '0, '0);
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic hit,
                        input logic [31:0] pa, input logic [3:0] attr);
        @(negedge clk);
        lk_va = va;
        @(negedge clk);
        chk({req, " hit"}, 32'(lk_hit), 32'(hit));
        chk({req, " pa"}, lk_pa, pa);
        chk({req, " attr"}, 32'(lk_attr), 32'(attr));
    endtask

    task automatic t_reset;
        chk("R1 base", 32'(lock_base), 0);
        chk("R1 vict", 32'(lock_vict), 0);
        chk("R1 busy", 32'(busy), 0);
        look("R1 lookup", 32'h0000_0000, 1'b0, 0, 0);
    endtask

    task automatic t_lock_rw;
        set_lock(3, 7);
        chk("R2 base", 32'(lock_base), 3);
        chk("R2 vict", 32'(lock_vict), 7);
        repeat (3) @(negedge clk);
        chk("R2 base held", 32'(lock_base), 3);
        set_lock(0, 0);
    endtask

    task automatic t_load_read;
        load(32'h0001_0004, 32'h8000_0005);
        chk("R3 load ok", 32'(last_err), 0);
        chk("R4 vict incr", 32'(lock_vict), 1);
        issue(3'd2, 0, 0, '0, '0, '0);
        set_lock(0, 0);
        issue(3'd4, 0, 0, '0, '0, '0);
        chk("R3 read tag", stage_tag, 32'h0001_0004);
        chk("R3 read data", stage_data, 32'h8000_0005);
        set_lock(0, 1);
    endtask

    task automatic t_sizes_and_priority;
        load(32'h0020_0005, 32'h9000_0003);
        load(32'h0300_0006, 32'hA000_0001);
        load(32'h0501_0004, 32'hC000_0006);
        load(32'h0500_0007, 32'hB000_0002);
        chk("R4 vict after loads", 32'(lock_vict), 5);
        look("R6 4K", 32'h0001_0FFF, 1'b1, 32'h8000_0FFF, 4'h5);
        look("R6 4K edge", 32'h0001_1000, 1'b0, 0, 0);
        look("R6 64K", 32'h0020_ABCD, 1'b1, 32'h9000_ABCD, 4'h3);
        look("R6 1M", 32'h030F_1234, 1'b1, 32'hA00F_1234, 4'h1);
        look("R6 16M", 32'h05AB_CDEF, 1'b1, 32'hB0AB_CDEF, 4'h2);
        look("R9 lowest wins", 32'h0501_0123, 1'b1, 32'hC000_0123, 4'h6);
    endtask

    task automatic t_reload_dup;
        load(32'h0001_0004, 32'hD000_0007);
        look("R10 new mapping", 32'h0001_0010, 1'b1, 32'hD000_0010, 4'h7);
        set_lock(0, 0);
        issue(3'd4, 0, 0, '0, '0, '0);
        chk("R10 old slot invalid", stage_tag, 32'h0001_0000);
        set_lock(0, 6);
    endtask

    task automatic t_flush_va;
        issue(3'd5, 0, 0, '0, '0, 32'h0501_0200);
        look("R7 small gone", 32'h0501_0123, 1'b0, 0, 0);
        look("R7 large gone", 32'h05AB_0000, 1'b0, 0, 0);
        look("R7 other kept", 32'h0020_0000, 1'b1, 32'h9000_0000, 4'h3);
    endtask

    task automatic t_wrap;
        set_lock(30, 31);
        load(32'h0800_0004, 32'hE000_0001);
        chk("R4 wrap to base", 32'(lock_vict), 30);
        load(32'h0900_0004, 32'hE100_0001);
        chk("R4 after wrap", 32'(lock_vict), 31);
        look("R4 slot31", 32'h0800_0044, 1'b1, 32'hE000_0044, 4'h1);
        look("R4 slot30", 32'h0900_0044, 1'b1, 32'hE100_0044, 4'h1);
    endtask

    task automatic t_full;
        set_lock(32, 5);
        load(32'h0700_0004, 32'h1234_0001);
        chk("R5 err", 32'(last_err), 1);
        chk("R5 vict kept", 32'(lock_vict), 5);
        look("R5 not written", 32'h0700_0000, 1'b0, 0, 0);
    endtask

    task automatic t_flush_all;
        set_lock(0, 8);
        load(32'h0A00_000C, 32'hF000_0000);
        issue(3'd6, 0, 0, '0, '0, '0);
        chk("R8 base", 32'(lock_base), 0);
        chk("R8 vict", 32'(lock_vict), 0);
        look("R8 preserved", 32'h0A00_0004, 1'b1, 32'hF000_0004, 4'h0);
        look("R8 cleared", 32'h0020_0000, 1'b0, 0, 0);
        look("R8 cleared2", 32'h0800_0000, 1'b0, 0, 0);
    endtask

    task automatic t_busy;
        // R11: a command during a load is not taken
        @(negedge clk);
        cmd_op = 3'd2; cmd_tag = 32'h0B00_0004; cmd_data = 32'h0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 3'd3;
        @(negedge clk);
        cmd_valid = 1'b1;
        chk("R11 busy", 32'(busy), 1);
        cmd_op = 3'd1; cmd_base = LK_W'(9); cmd_vict = LK_W'(9);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 lock write ignored base", 32'(lock_base), 0);
        chk("R11 vict after load", 32'(lock_vict), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock_rw();
        t_load_read();
        t_sizes_and_priority();
        t_reload_dup();
        t_flush_va();
        t_wrap();
        t_full();
        t_flush_all();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule